// File: doc/BRIEF.md
# Chunked DMA Transfer Sequencer

This block accepts one DMA job at a time and drives a downstream bus-cycle engine with a series of bounded bursts. A job is described by a transfer direction, a byte start address, a byte end address and a total word count. The sequencer cuts the job into chunks of at most `MAX_CHUNK` (default 512) words. For each chunk it raises a one-cycle request that carries the chunk's byte address and word count. It then waits until the engine reports that the chunk finished or that it timed out.

Alongside each request the block gives the word offset into the caller's buffer where the chunk's data belongs. Because bus addresses count bytes and a word spans two bytes, this offset is half the byte distance from the job start. The same value also tells how many words have already moved in earlier chunks. When the last chunk finishes, or as soon as any chunk times out, the block pulses a completion strobe and holds a pass/fail flag until the next job starts.

Top module: `chunked_dma_seq`

## Requirements
- R1: After reset, busy, done, success and the chunk request are all low.
- R2: When idle, a start pulse latches the job. One cycle later the first chunk request appears at the job start address with buffer offset 0, and busy goes high.
- R3: Every chunk's word count is the smaller of `MAX_CHUNK` (512) and the words still outstanding, and it is never zero.
- R4: Each later chunk begins at the previous chunk's byte address plus twice its word count. The buffer offset output equals (chunk address minus job start) / 2, which is also the number of words already transferred.
- R5: A chunk request lasts exactly one cycle. After a chunk-done response that leaves words outstanding, the next request follows in the very next cycle.
- R6: A timeout response aborts the job. In the next cycle done pulses with success low, and no further chunk is requested.
- R7: When the final chunk's done response arrives, done pulses for exactly one cycle in the next cycle with success high, and busy drops the cycle after that.
- R8: A start pulse that arrives while a job is in progress is ignored. The running job's addresses and counts are unaffected.
- R9: A job with a word count of zero issues no chunk. Done pulses one cycle after the start pulse, with success high.
- R10: The direction (1 = write, 0 = read) and the end address shown with every chunk are the values latched at start. They stay constant across the job even if the job inputs change.
- R11: Chunk-done and timeout responses have no effect unless a chunk is outstanding. A response seen during the request cycle itself is ignored.
- R12: If chunk-done and timeout arrive in the same cycle, the timeout wins and the job fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse for a new job |
| wr_i | input | 1 | Job direction: 1 write, 0 read |
| base_addr_i | input | ADDR_W | Job byte start address |
| last_addr_i | input | ADDR_W | Job byte end address |
| word_cnt_i | input | WC_W | Total words in the job |
| xfer_done_i | input | 1 | Bus engine: current chunk finished |
| xfer_timeout_i | input | 1 | Bus engine: current chunk timed out |
| chunk_req_o | output | 1 | One-cycle chunk request |
| chunk_wr_o | output | 1 | Latched direction for the chunk |
| chunk_addr_o | output | ADDR_W | Chunk byte start address |
| chunk_words_o | output | CHUNK_W | Chunk word count |
| buf_word_off_o | output | OFF_W | Buffer word offset, equal to words already moved |
| job_last_addr_o | output | ADDR_W | Latched job end address |
| busy_o | output | 1 | A job is in progress |
| done_o | output | 1 | One-cycle completion strobe |
| success_o | output | 1 | Outcome of the last job, valid with done and held afterwards |

## Verification
The hardest situations to reach from the ports are responses that land in the wrong cycle. These are a done response during the request cycle itself, and a done and a timeout asserted together. The bench drives the engine inputs by hand at exact negative edges. In one scenario it raises chunk-done and a second start pulse in the same request cycle, then checks that the following chunk still begins where the first chunk's real completion puts it. In the next cycle it raises both responses together. Jobs of 1300, 512, 600 and 1000 words cover the short final chunk, the chunk that exactly fills a burst, and aborts in the middle of a job.

// File: rtl/dchk_pkg.sv
package dchk_pkg;
    parameter int unsigned ADDR_W    = 22;
    parameter int unsigned WC_W      = 16;
    parameter int unsigned MAX_CHUNK = 512;
    localparam int unsigned CHUNK_W  = $clog2(MAX_CHUNK + 1);
    localparam int unsigned OFF_W    = ADDR_W - 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_FIN
    } seq_state_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] last;
    } job_t;

    function automatic logic [CHUNK_W-1:0] clamp_chunk(input logic [WC_W-1:0] rem);
        if (rem > WC_W'(MAX_CHUNK))
            return CHUNK_W'(MAX_CHUNK);
        else
            return rem[CHUNK_W-1:0];
    endfunction
endpackage

// File: rtl/dchk_planner.sv
module dchk_planner
    import dchk_pkg::*;
(
    input  logic [ADDR_W-1:0]  cur_addr,
    input  logic [ADDR_W-1:0]  base_addr,
    input  logic [WC_W-1:0]    remaining,
    output logic [CHUNK_W-1:0] chunk_words,
    output logic [ADDR_W-1:0]  next_addr,
    output logic [WC_W-1:0]    next_remaining,
    output logic [OFF_W-1:0]   word_off
);
    logic [ADDR_W-1:0] byte_dist;

    always_comb begin
        chunk_words    = clamp_chunk(remaining);
        next_addr      = cur_addr + (ADDR_W'(chunk_words) << 1);
        next_remaining = remaining - WC_W'(chunk_words);
        byte_dist      = cur_addr - base_addr;
        word_off       = byte_dist[ADDR_W-1:1];
    end
endmodule

// File: rtl/dchk_ctrl.sv
module dchk_ctrl
    import dchk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic               wr_i,
    input  logic [ADDR_W-1:0]  base_addr_i,
    input  logic [ADDR_W-1:0]  last_addr_i,
    input  logic [WC_W-1:0]    word_cnt_i,
    input  logic               xfer_done_i,
    input  logic               xfer_timeout_i,
    input  logic [CHUNK_W-1:0] chunk_words,
    input  logic [ADDR_W-1:0]  next_addr,
    input  logic [WC_W-1:0]    next_remaining,
    output job_t               job_q,
    output logic [ADDR_W-1:0]  cur_addr_q,
    output logic [WC_W-1:0]    remaining_q,
    output logic               chunk_req_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               success_o
);
    seq_state_e state_q;
    logic       ok_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            job_q       <= '0;
            cur_addr_q  <= '0;
            remaining_q <= '0;
            ok_q        <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        job_q       <= '{wr: wr_i, base: base_addr_i, last: last_addr_i};
                        cur_addr_q  <= base_addr_i;
                        remaining_q <= word_cnt_i;
                        if (word_cnt_i == '0) begin
                            ok_q    <= 1'b1;
                            state_q <= ST_FIN;
                        end else begin
                            ok_q    <= 1'b0;
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (xfer_timeout_i) begin
                        ok_q    <= 1'b0;
                        state_q <= ST_FIN;
                    end else if (xfer_done_i) begin
                        cur_addr_q  <= next_addr;
                        remaining_q <= next_remaining;
                        if (next_remaining == '0) begin
                            ok_q    <= 1'b1;
                            state_q <= ST_FIN;
                        end else begin
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                ST_FIN: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign chunk_req_o = (state_q == ST_ISSUE);
    assign busy_o      = (state_q != ST_IDLE);
    assign done_o      = (state_q == ST_FIN);
    assign success_o   = ok_q;

    assert_req_single_R5: assert property (@(posedge clk) disable iff (rst)
        chunk_req_o |=> !chunk_req_o);

    assert_chunk_bound_R3: assert property (@(posedge clk) disable iff (rst)
        chunk_req_o |-> (chunk_words != '0) && (chunk_words <= CHUNK_W'(MAX_CHUNK)));

    assert_timeout_fails_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && xfer_timeout_i) |=> (done_o && !success_o));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_job_stable_R10: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> (!busy_o || $stable(job_q)));

    assert_advance_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && xfer_done_i && !xfer_timeout_i && next_remaining != '0)
        |=> cur_addr_q == $past(cur_addr_q) + (ADDR_W'($past(chunk_words)) << 1));
endmodule

// File: rtl/chunked_dma_seq.sv
module chunked_dma_seq
    import dchk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic               wr_i,
    input  logic [ADDR_W-1:0]  base_addr_i,
    input  logic [ADDR_W-1:0]  last_addr_i,
    input  logic [WC_W-1:0]    word_cnt_i,
    input  logic               xfer_done_i,
    input  logic               xfer_timeout_i,
    output logic               chunk_req_o,
    output logic               chunk_wr_o,
    output logic [ADDR_W-1:0]  chunk_addr_o,
    output logic [CHUNK_W-1:0] chunk_words_o,
    output logic [OFF_W-1:0]   buf_word_off_o,
    output logic [ADDR_W-1:0]  job_last_addr_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               success_o
);
    job_t               job_q;
    logic [ADDR_W-1:0]  cur_addr_q;
    logic [WC_W-1:0]    remaining_q;
    logic [CHUNK_W-1:0] chunk_words;
    logic [ADDR_W-1:0]  next_addr;
    logic [WC_W-1:0]    next_remaining;

    dchk_planner u_plan (
        .cur_addr       (cur_addr_q),
        .base_addr      (job_q.base),
        .remaining      (remaining_q),
        .chunk_words    (chunk_words),
        .next_addr      (next_addr),
        .next_remaining (next_remaining),
        .word_off       (buf_word_off_o)
    );

    dchk_ctrl u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .start_i        (start_i),
        .wr_i           (wr_i),
        .base_addr_i    (base_addr_i),
        .last_addr_i    (last_addr_i),
        .word_cnt_i     (word_cnt_i),
        .xfer_done_i    (xfer_done_i),
        .xfer_timeout_i (xfer_timeout_i),
        .chunk_words    (chunk_words),
        .next_addr      (next_addr),
        .next_remaining (next_remaining),
        .job_q          (job_q),
        .cur_addr_q     (cur_addr_q),
        .remaining_q    (remaining_q),
        .chunk_req_o    (chunk_req_o),
        .busy_o         (busy_o),
        .done_o         (done_o),
        .success_o      (success_o)
    );

    assign chunk_wr_o      = job_q.wr;
    assign chunk_addr_o    = cur_addr_q;
    assign chunk_words_o   = chunk_words;
    assign job_last_addr_o = job_q.last;
endmodule

// File: tb/tb_chunked_dma_seq.sv
module tb_chunked_dma_seq;
    import dchk_pkg::*;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               start_i = 1'b0;
    logic               wr_i = 1'b0;
    logic [ADDR_W-1:0]  base_addr_i = '0;
    logic [ADDR_W-1:0]  last_addr_i = '0;
    logic [WC_W-1:0]    word_cnt_i = '0;
    logic               xfer_done_i = 1'b0;
    logic               xfer_timeout_i = 1'b0;
    logic               chunk_req_o, chunk_wr_o, busy_o, done_o, success_o;
    logic [ADDR_W-1:0]  chunk_addr_o, job_last_addr_o;
    logic [CHUNK_W-1:0] chunk_words_o;
    logic [OFF_W-1:0]   buf_word_off_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    chunked_dma_seq dut (
        .clk(clk), .rst(rst), .start_i(start_i), .wr_i(wr_i),
        .base_addr_i(base_addr_i), .last_addr_i(last_addr_i), .word_cnt_i(word_cnt_i),
        .xfer_done_i(xfer_done_i), .xfer_timeout_i(xfer_timeout_i),
        .chunk_req_o(chunk_req_o), .chunk_wr_o(chunk_wr_o), .chunk_addr_o(chunk_addr_o),
        .chunk_words_o(chunk_words_o), .buf_word_off_o(buf_word_off_o),
        .job_last_addr_o(job_last_addr_o), .busy_o(busy_o), .done_o(done_o),
        .success_o(success_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic eq(input string req, input longint act, input longint exp);
        chk(act == exp, req, act, exp);
    endtask

    // Runs one job; abort_at >= 0 times out that chunk index.
    task automatic run_job(input bit wr, input longint sa, input longint wc, input int abort_at);
        longint ea = (wc == 0) ? sa : sa + 2 * wc - 2;
        longint rem = wc;
        longint addr = sa;
        longint w;
        int idx = 0;
        @(negedge clk);
        start_i = 1'b1; wr_i = wr; base_addr_i = ADDR_W'(sa);
        last_addr_i = ADDR_W'(ea); word_cnt_i = WC_W'(wc);
        @(negedge clk);
        start_i = 1'b0; wr_i = ~wr; base_addr_i = '1; last_addr_i = '0; word_cnt_i = '1;
        if (wc == 0) begin
            eq("R9 done", done_o, 1); eq("R9 success", success_o, 1); eq("R9 no req", chunk_req_o, 0);
            @(negedge clk);
            eq("R9 done low", done_o, 0); eq("R9 idle", busy_o, 0);
            return;
        end
        eq("R2 busy", busy_o, 1);
        while (rem > 0) begin
            w = (rem > MAX_CHUNK) ? MAX_CHUNK : rem;
            eq("R2 R5 req", chunk_req_o, 1);
            eq("R4 addr", chunk_addr_o, addr);
            eq("R3 words", chunk_words_o, w);
            eq("R4 offset", buf_word_off_o, (addr - sa) / 2);
            eq("R10 dir", chunk_wr_o, wr);
            eq("R10 end", job_last_addr_o, ea);
            @(negedge clk);
            eq("R5 req one cycle", chunk_req_o, 0);
            if (idx == abort_at) begin
                xfer_timeout_i = 1'b1;
                @(negedge clk);
                xfer_timeout_i = 1'b0;
                eq("R6 done", done_o, 1); eq("R6 success", success_o, 0); eq("R6 no req", chunk_req_o, 0);
                @(negedge clk);
                eq("R6 idle", busy_o, 0); eq("R6 no req after", chunk_req_o, 0);
                return;
            end
            xfer_done_i = 1'b1;
            @(negedge clk);
            xfer_done_i = 1'b0;
            rem -= w; addr += 2 * w; idx++;
        end
        eq("R7 done", done_o, 1); eq("R7 success", success_o, 1); eq("R7 no req", chunk_req_o, 0);
        @(negedge clk);
        eq("R7 done one cycle", done_o, 0); eq("R7 idle", busy_o, 0); eq("R7 success held", success_o, 1);
    endtask

    task automatic t_reset();
        eq("R1 busy", busy_o, 0); eq("R1 done", done_o, 0);
        eq("R1 success", success_o, 0); eq("R1 req", chunk_req_o, 0);
    endtask

    task automatic t_long_job();   run_job(1'b1, 'h1000, 1300, -1); endtask
    task automatic t_exact_chunk(); run_job(1'b0, 'h2000, 512, -1); endtask
    task automatic t_zero();       run_job(1'b1, 'h0400, 0, -1); endtask
    task automatic t_abort();      run_job(1'b0, 'h3000, 1000, 1); endtask

    task automatic t_ignored_inputs();
        @(negedge clk);
        start_i = 1'b1; wr_i = 1'b1; base_addr_i = 'h200; last_addr_i = 'h200 + 1198; word_cnt_i = 600;
        xfer_done_i = 1'b1;   // R11: idle, no chunk outstanding
        @(negedge clk);
        eq("R11 req", chunk_req_o, 1); eq("R11 addr", chunk_addr_o, 'h200);
        start_i = 1'b1; base_addr_i = 'h5000; word_cnt_i = 7; // R8 and R11 during request cycle
        @(negedge clk);
        start_i = 1'b0; xfer_done_i = 1'b0;
        eq("R11 waiting", chunk_req_o, 0); eq("R11 no done", done_o, 0);
        xfer_done_i = 1'b1;
        @(negedge clk);
        xfer_done_i = 1'b0;
        eq("R8 second req", chunk_req_o, 1);
        eq("R8 addr", chunk_addr_o, 'h200 + 1024);
        eq("R8 words", chunk_words_o, 88);
        eq("R8 offset", buf_word_off_o, 512);
        @(negedge clk);
        xfer_done_i = 1'b1; xfer_timeout_i = 1'b1;
        @(negedge clk);
        xfer_done_i = 1'b0; xfer_timeout_i = 1'b0;
        eq("R12 done", done_o, 1); eq("R12 success", success_o, 0);
        @(negedge clk);
        eq("R12 idle", busy_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_long_job();
        t_exact_chunk();
        t_zero();
        t_abort();
        t_ignored_inputs();
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule